// File: doc/BRIEF.md
# Dual-Clock Stream FIFO

This block moves a stream of data words from one clock domain into another clock domain that has no fixed relation to the first. The producer uses a valid/ready input port clocked by `wr_clk`. The consumer uses a valid/ready output port clocked by `rd_clk`. Each domain has its own active-low synchronous reset. Words leave in the order they were accepted. Nothing is dropped, and no word is produced twice.

Each side keeps a binary pointer and a Gray-coded copy of it. Both pointers are one bit wider than the storage address, so the FIFO can tell "all slots used" apart from "no slots used". Only the registered Gray copy crosses into the other domain, and it passes through a chain of flip-flops clocked by the receiving side. The write side compares its own Gray pointer with the synchronized read pointer to decide that the FIFO is full. The read side compares its Gray pointer with the synchronized write pointer to decide that it is empty.

Because a pointer reaches the other side a few cycles late, both flags are pessimistic. A slot freed by the reader, or a word added by the writer, shows up on the opposite side only after a short delay.

Back-pressure rules:
- A word is taken on a `wr_clk` edge when `wr_valid` and `wr_ready` are both high.
- A word is consumed on a `rd_clk` edge when `rd_valid` and `rd_ready` are both high.
- While `rd_valid` is high and `rd_ready` is low, the offered word stays unchanged.
- `DEPTH` must be a power of two and at least 4.

Top module: `xclk_stream_fifo`

## Requirements
- R1: After both resets, `wr_ready` is 1 and `rd_valid` is 0, and any words stored before the reset are discarded.
- R2: With no reads, `wr_ready` falls to 0 right after the DEPTH-th accepted word. The count of stored, unread words never exceeds DEPTH.
- R3: A word offered while `wr_ready` is 0 is not stored, and the write pointer does not move. With DEPTH+4 offers to a FIFO that is not being read, exactly DEPTH words are accepted.
- R4: `rd_valid` is 0 whenever nothing is stored. Holding `rd_ready` high while `rd_valid` is 0 does not move the read pointer, so the next word written is the next word read.
- R5: Words come out in the order they were accepted, with their values unchanged, for any mix of write and read pauses, including when the pointers wrap.
- R6: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` stays 1 and `rd_data` holds its value on the next `rd_clk` edge.
- R7: A word written into an empty FIFO makes `rd_valid` rise within 1 to 4 `rd_clk` cycles, counted from the end of the write.
- R8: When a full FIFO gives up one word on the read side, `wr_ready` rises again within 1 to 4 `wr_clk` cycles, counted from the end of that read.
- R9: Each Gray pointer changes in at most one bit per cycle of its own clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain synchronous reset, active low |
| wr_data | input | DATA_W | Word offered by the producer |
| wr_valid | input | 1 | Producer has a word on `wr_data` |
| wr_ready | output | 1 | FIFO can take a word (not full) |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain synchronous reset, active low |
| rd_data | output | DATA_W | Oldest stored word |
| rd_valid | output | 1 | A word is available (not empty) |
| rd_ready | input | 1 | Consumer takes the word on `rd_data` |

## Verification
The assertions check these rules on every clock edge:
- Each Gray pointer steps by a single bit (R9).
- Neither pointer moves while its flag blocks it (R3, R4).
- The write side never sees more than DEPTH words outstanding (R2).
- The offered read word holds while it is stalled (R6).

Only the bench scenarios can show the end-to-end properties. These are word order and word values across wrap-around under different pause patterns, and the exact number of words accepted when the FIFO fills. They also include the 1-to-4-cycle delay bounds for the flags to cross between domains, and the loss of stored contents on reset.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

  typedef logic [31:0] ptr_word_t;

  function automatic ptr_word_t bin_to_gray(ptr_word_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_word_t gray_to_bin(ptr_word_t g);
    ptr_word_t b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = g[i] ^ b[i+1];
    end
    return b;
  endfunction

endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/xfifo_store.sv
module xfifo_store #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] slots [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) slots[waddr] <= wdata;
  end

  assign rdata = slots[raddr];

endmodule

// File: rtl/xfifo_wr_side.sv
module xfifo_wr_side #(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int PTR_W      = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PTR_W-1:0]  rgray_x,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [PTR_W-1:0]  wgray_q
);
  import xfifo_pkg::*;

  localparam logic [PTR_W-1:0] FULL_MASK = PTR_W'(3) << (PTR_W - 2);
  localparam logic [PTR_W-1:0] DEPTH_P   = PTR_W'(1) << ADDR_W;

  logic [PTR_W-1:0] wbin_q, wbin_d, wgray_d, rgray_s, rbin_s;
  logic             full;

  xfifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_rsync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rgray_x),
    .q     (rgray_s)
  );

  // Full: the two top Gray bits differ and the remaining bits match.
  assign full      = (wgray_q == (rgray_s ^ FULL_MASK));
  assign in_ready  = !full;
  assign mem_we    = in_valid && !full;
  assign mem_waddr = wbin_q[ADDR_W-1:0];

  always_comb begin
    wbin_d  = wbin_q + PTR_W'(mem_we);
    wgray_d = PTR_W'(bin_to_gray(ptr_word_t'(wbin_d)));
    rbin_s  = PTR_W'(gray_to_bin(ptr_word_t'(rgray_s)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  p_wgray_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(wbin_q));

  p_occ_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wbin_q - rbin_s) <= DEPTH_P);

endmodule

// File: rtl/xfifo_rd_side.sv
module xfifo_rd_side #(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int PTR_W      = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              out_valid,
  input  logic              out_ready,
  input  logic [PTR_W-1:0]  wgray_x,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic [PTR_W-1:0]  rgray_q
);
  import xfifo_pkg::*;

  logic [PTR_W-1:0] rbin_q, rbin_d, rgray_d, wgray_s;
  logic             empty, pop;

  xfifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_wsync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (wgray_x),
    .q     (wgray_s)
  );

  assign empty     = (rgray_q == wgray_s);
  assign out_valid = !empty;
  assign pop       = out_valid && out_ready;
  assign mem_raddr = rbin_q[ADDR_W-1:0];

  always_comb begin
    rbin_d  = rbin_q + PTR_W'(pop);
    rgray_d = PTR_W'(bin_to_gray(ptr_word_t'(rbin_d)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
    end
  end

  p_rgray_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |=> $stable(rbin_q));

endmodule

// File: rtl/xclk_stream_fifo.sv
module xclk_stream_fifo #(
  parameter int DATA_W      = 32,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(DEPTH),
  localparam int PTR_W      = ADDR_W + 1
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              rd_ready
);

  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [PTR_W-1:0]  wgray, rgray;

  xfifo_wr_side #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_wr (
    .clk       (wr_clk),
    .rst_n     (wr_rst_n),
    .in_valid  (wr_valid),
    .in_ready  (wr_ready),
    .rgray_x   (rgray),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .wgray_q   (wgray)
  );

  xfifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .wclk  (wr_clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (wr_data),
    .raddr (mem_raddr),
    .rdata (rd_data)
  );

  xfifo_rd_side #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_rd (
    .clk       (rd_clk),
    .rst_n     (rd_rst_n),
    .out_valid (rd_valid),
    .out_ready (rd_ready),
    .wgray_x   (wgray),
    .mem_raddr (mem_raddr),
    .rgray_q   (rgray)
  );

  p_rd_hold_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

endmodule

// File: tb/xclk_stream_fifo_tb.sv
module xclk_stream_fifo_tb;

  localparam int CLK_PERIOD    = 10;
  localparam int RD_CLK_PERIOD = 14;
  localparam int DATA_W        = 32;
  localparam int DEPTH         = 16;

  typedef struct packed {
    logic [31:0] beats;
    logic [31:0] seed;
    logic [31:0] wgap;
    logic [31:0] rgap;
    logic [31:0] last;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{32'd8,  32'h0000_0100, 32'd0, 32'd0, 32'h0000_0107},
    '{32'd20, 32'h0000_2000, 32'd0, 32'd3, 32'h0000_2013},
    '{32'd12, 32'h0000_00A0, 32'd4, 32'd0, 32'h0000_00AB},
    '{32'd40, 32'hFFFF_FFF0, 32'd1, 32'd2, 32'h0000_0017},
    '{32'd33, 32'h5555_0000, 32'd2, 32'd1, 32'h5555_0020}
  };

  logic              wr_clk = 1'b0;
  logic              rd_clk = 1'b0;
  logic              wr_rst_n = 1'b0;
  logic              rd_rst_n = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              wr_valid = 1'b0;
  logic              wr_ready;
  logic [DATA_W-1:0] rd_data;
  logic              rd_valid;
  logic              rd_ready = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  initial begin
    #1;
    forever #(RD_CLK_PERIOD/2) rd_clk = ~rd_clk;
  end

  xclk_stream_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .wr_clk   (wr_clk),
    .wr_rst_n (wr_rst_n),
    .wr_data  (wr_data),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    wr_valid = 1'b0;
    rd_ready = 1'b0;
    @(negedge wr_clk) wr_rst_n = 1'b0;
    @(negedge rd_clk) rd_rst_n = 1'b0;
    repeat (4) @(negedge rd_clk);
    @(negedge wr_clk) wr_rst_n = 1'b1;
    @(negedge rd_clk) rd_rst_n = 1'b1;
    repeat (2) @(negedge wr_clk);
  endtask

  // Offer n words seed, seed+1, ... with gap idle cycles after each accept.
  task automatic push_seq(input logic [31:0] n, input logic [31:0] seed,
                          input logic [31:0] gap);
    bit rdy;
    @(negedge wr_clk);
    for (int i = 0; i < int'(n); i++) begin
      wr_valid = 1'b1;
      wr_data  = seed + 32'(i);
      do begin
        rdy = wr_ready;
        @(negedge wr_clk);
      end while (!rdy);
      wr_valid = 1'b0;
      repeat (int'(gap)) @(negedge wr_clk);
    end
    wr_valid = 1'b0;
  endtask

  // Take n words; each must equal seed+i (R5).
  task automatic pop_seq(input logic [31:0] n, input logic [31:0] seed,
                         input logic [31:0] gap, output logic [31:0] last);
    bit v;
    logic [31:0] dat;
    last = '0;
    @(negedge rd_clk);
    for (int i = 0; i < int'(n); i++) begin
      rd_ready = 1'b1;
      do begin
        v   = rd_valid;
        dat = rd_data;
        @(negedge rd_clk);
      end while (!v);
      check(dat == seed + 32'(i), "R5", "word order/value", dat, seed + 32'(i));
      last = dat;
      rd_ready = 1'b0;
      repeat (int'(gap)) @(negedge rd_clk);
    end
    rd_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] last;
    int acc;
    int cnt;
    bit rdy;

    // Reset state (R1)
    repeat (3) @(negedge wr_clk);
    @(negedge wr_clk) wr_rst_n = 1'b1;
    @(negedge rd_clk) rd_rst_n = 1'b1;
    repeat (2) @(negedge wr_clk);
    check(wr_ready == 1'b1, "R1", "wr_ready after reset", 32'(wr_ready), 32'd1);
    check(rd_valid == 1'b0, "R1", "rd_valid after reset", 32'(rd_valid), 32'd0);

    // Table-driven streaming runs (R5, R4)
    for (int v = 0; v < NVEC; v++) begin
      fork
        push_seq(VECS[v].beats, VECS[v].seed, VECS[v].wgap);
        pop_seq(VECS[v].beats, VECS[v].seed, VECS[v].rgap, last);
      join
      check(last == VECS[v].last, "R5", "last word of run", last, VECS[v].last);
      repeat (6) @(negedge rd_clk);
      check(rd_valid == 1'b0, "R4", "empty after run", 32'(rd_valid), 32'd0);
    end

    // Fill with no reads (R2, R3)
    acc = 0;
    for (int k = 0; k < DEPTH + 4; k++) begin
      @(negedge wr_clk);
      wr_valid = 1'b1;
      wr_data  = 32'hC000 + 32'(acc);
      rdy      = wr_ready;
      @(posedge wr_clk);
      if (rdy) acc++;
    end
    @(negedge wr_clk);
    check(acc == DEPTH, "R3", "words accepted into full FIFO", 32'(acc), 32'(DEPTH));
    check(wr_ready == 1'b0, "R2", "wr_ready when full", 32'(wr_ready), 32'd0);
    wr_valid = 1'b0;

    // One read frees a slot; wr_ready recovers within 1..4 wr cycles (R8)
    pop_seq(32'd1, 32'hC000, 32'd0, last);
    cnt = 0;
    while (!wr_ready && cnt < 20) begin
      @(negedge wr_clk);
      cnt++;
    end
    check(cnt >= 1 && cnt <= 4, "R8", "wr_ready recovery cycles", 32'(cnt), 32'd4);

    // Drain; the word refused while full must never appear (R3)
    pop_seq(32'(DEPTH - 1), 32'hC001, 32'd0, last);
    repeat (8) @(negedge rd_clk);
    check(rd_valid == 1'b0, "R3", "no extra word after drain", 32'(rd_valid), 32'd0);

    // Latency of a single word into empty FIFO (R7), then hold (R6)
    push_seq(32'd1, 32'h0000_BEEF, 32'd0);
    cnt = 0;
    while (!rd_valid && cnt < 20) begin
      @(negedge rd_clk);
      cnt++;
    end
    check(cnt >= 1 && cnt <= 4, "R7", "rd_valid latency cycles", 32'(cnt), 32'd4);
    for (int h = 0; h < 5; h++) begin
      @(negedge rd_clk);
      check(rd_valid == 1'b1 && rd_data == 32'h0000_BEEF, "R6", "held word while stalled",
            rd_data, 32'h0000_BEEF);
    end
    pop_seq(32'd1, 32'h0000_BEEF, 32'd0, last);

    // Read attempts on empty FIFO have no effect (R4)
    @(negedge rd_clk) rd_ready = 1'b1;
    for (int e = 0; e < 6; e++) begin
      @(negedge rd_clk);
      check(rd_valid == 1'b0, "R4", "rd_valid on empty with rd_ready", 32'(rd_valid), 32'd0);
    end
    rd_ready = 1'b0;
    push_seq(32'd1, 32'h0000_1234, 32'd0);
    pop_seq(32'd1, 32'h0000_1234, 32'd0, last);
    check(last == 32'h0000_1234, "R4", "word after empty reads", last, 32'h0000_1234);

    // Reset with stored words discards them (R1)
    push_seq(32'd3, 32'h0000_7700, 32'd0);
    repeat (6) @(negedge rd_clk);
    check(rd_valid == 1'b1, "R1", "words present before reset", 32'(rd_valid), 32'd1);
    do_reset();
    repeat (6) @(negedge rd_clk);
    check(rd_valid == 1'b0, "R1", "rd_valid after mid-run reset", 32'(rd_valid), 32'd0);
    check(wr_ready == 1'b1, "R1", "wr_ready after mid-run reset", 32'(wr_ready), 32'd1);
    push_seq(32'd2, 32'h0000_8800, 32'd0);
    pop_seq(32'd2, 32'h0000_8800, 32'd0, last);
    check(last == 32'h0000_8801, "R1", "fresh stream after reset", last, 32'h0000_8801);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule